// File: doc/BRIEF.md
# Split-Lane Arithmetic Unit with Add-Compare-Select

This block is the arithmetic stage for accumulator-width data in a signal-processing datapath. One registered stage covers three kinds of work, chosen by a 3-bit opcode. It runs full-width 40-bit addition, subtraction and bitwise logic. It runs a split mode that treats the low 32 bits as two independent 16-bit lanes, used to form branch-metric distances. It also runs an add-compare-select step for Viterbi decoding.

In add-compare-select, the two operands are the path metrics held in two accumulators. A signed branch metric is added to the first path and subtracted from the second. The smaller sum survives. It is returned with a destination index that names one of the two source accumulators, and a decision bit records which path won so a separate traceback stage can store it. Every operation returns its result one clock after it is issued. The outputs keep their values until the next operation is issued.

Top module: `acs_alu`

## Requirements
- R1: After reset, out_valid, result, dest_idx, flag_zero, flag_neg and flag_decision are all 0.
- R2: An operation presented with in_valid high at a rising edge appears on the outputs after that edge, with out_valid high for exactly that cycle. While in_valid is low, out_valid is 0 and result, dest_idx and the flags keep their values.
- R3: Opcode 0 gives op_a + op_b and opcode 1 gives op_a - op_b, both in 40-bit two's complement that wraps modulo 2^40.
- R4: Opcode 2 gives bitwise AND, opcode 3 gives bitwise OR and opcode 4 gives bitwise XOR of the two 40-bit operands.
- R5: Opcode 5 (split add) and opcode 6 (split subtract) work on lanes bits [15:0] and [31:16] separately. No carry or borrow passes between the lanes. Result bits [39:32] copy result bit 31, and operand bits [39:32] have no effect.
- R6: Opcode 7 (add-compare-select) forms S0 = op_a + bm and S1 = op_b - bm, where bm is branch_metric sign-extended to 40 bits. It returns the signed smaller of S0 and S1 and sets flag_decision to 1 when S1 is strictly smaller.
- R7: When S0 equals S1 in add-compare-select, the result is S0 and flag_decision is 0.
- R8: For every opcode, dest_idx is src_b_idx when dest_sel is 1 and src_a_idx when dest_sel is 0.
- R9: flag_zero is 1 when the result is 0, and flag_neg equals result bit 39. flag_decision is 0 for every opcode other than 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Issues an operation this cycle |
| opcode | input | 3 | Operation code (0 add ... 7 add-compare-select) |
| op_a | input | 40 | First operand / first path metric |
| op_b | input | 40 | Second operand / second path metric |
| branch_metric | input | 16 | Signed branch metric for add-compare-select |
| src_a_idx | input | 3 | Accumulator index of op_a |
| src_b_idx | input | 3 | Accumulator index of op_b |
| dest_sel | input | 1 | 1 writes back to the op_b accumulator, 0 to the op_a one |
| out_valid | output | 1 | Result registers were loaded at the last edge |
| result | output | 40 | Operation result |
| dest_idx | output | 3 | Accumulator index to write result into |
| flag_zero | output | 1 | Result equals zero |
| flag_neg | output | 1 | Result sign bit |
| flag_decision | output | 1 | Survivor decision, 1 when the second path wins |

## Verification
The properties assume that opcode, operands and indices are known values whenever in_valid is high. They also assume in_valid stays low until the internal reset synchronizer has released, since any earlier request is dropped. The stimulus changes inputs only on falling edges, raises in_valid for one cycle per operation, and holds in_valid low through reset and for several cycles after it. The add-compare-select cases use path metrics well inside the 40-bit range, so the signed comparison is never affected by wrap-around.

// File: rtl/acs_alu_pkg.sv
package acs_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SADD = 3'd5,
    OP_SSUB = 3'd6,
    OP_ACS  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic decision;
  } alu_flags_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W    = 40,
  parameter int LANE_W    = 16,
  parameter int NUM_LANES = 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              split,
  output logic [DATA_W-1:0] sum
);
  localparam int SPLIT_W = LANE_W * NUM_LANES;
  localparam int EXT_W   = DATA_W - SPLIT_W;

  logic [DATA_W-1:0]  b_inv;
  logic [DATA_W-1:0]  full_sum;
  logic [SPLIT_W-1:0] split_vec;

  always_comb begin
    b_inv    = sub ? ~b : b;
    full_sum = a + b_inv + {{(DATA_W-1){1'b0}}, sub};
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_b;
    always_comb begin
      lane_b = sub ? ~b[g*LANE_W +: LANE_W] : b[g*LANE_W +: LANE_W];
      split_vec[g*LANE_W +: LANE_W] = a[g*LANE_W +: LANE_W] + lane_b
                                      + {{(LANE_W-1){1'b0}}, sub};
    end
  end

  always_comb begin
    if (split) sum = {{EXT_W{split_vec[SPLIT_W-1]}}, split_vec};
    else       sum = full_sum;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acs_alu_pkg::*;
#(
  parameter int DATA_W = 40
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] out
);
  always_comb begin
    case (op)
      OP_AND:  out = a & b;
      OP_OR:   out = a | b;
      OP_XOR:  out = a ^ b;
      default: out = '0;
    endcase
  end
endmodule

// File: rtl/alu_acs.sv
module alu_acs #(
  parameter int DATA_W = 40,
  parameter int BM_W   = 16
) (
  input  logic [DATA_W-1:0] pm_first,
  input  logic [DATA_W-1:0] pm_second,
  input  logic [BM_W-1:0]   bm,
  output logic [DATA_W-1:0] survivor,
  output logic              take_second
);
  localparam int EXT_W = DATA_W - BM_W;

  logic [DATA_W-1:0] bm_ext;
  logic [DATA_W-1:0] cand0;
  logic [DATA_W-1:0] cand1;

  always_comb begin
    bm_ext      = {{EXT_W{bm[BM_W-1]}}, bm};
    cand0       = pm_first + bm_ext;
    cand1       = pm_second - bm_ext;
    take_second = $signed(cand1) < $signed(cand0);
    survivor    = take_second ? cand1 : cand0;
  end
endmodule

// File: rtl/acs_alu.sv
module acs_alu
  import acs_alu_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int LANE_W = 16,
  parameter int BM_W   = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [BM_W-1:0]   branch_metric,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic              dest_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              flag_zero,
  output logic              flag_neg,
  output logic              flag_decision
);
  localparam int NUM_LANES = 2;

  // reset synchronizer: asserts at once, releases on clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  alu_op_e op;
  assign op = alu_op_e'(opcode);

  logic              is_sub, is_split;
  logic [DATA_W-1:0] arith_out, logic_out, acs_out;
  logic              acs_second;

  assign is_sub   = (op == OP_SUB) || (op == OP_SSUB);
  assign is_split = (op == OP_SADD) || (op == OP_SSUB);

  alu_arith #(.DATA_W(DATA_W), .LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_arith (
    .a(op_a), .b(op_b), .sub(is_sub), .split(is_split), .sum(arith_out)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(op_a), .b(op_b), .op(op), .out(logic_out)
  );

  alu_acs #(.DATA_W(DATA_W), .BM_W(BM_W)) u_acs (
    .pm_first(op_a), .pm_second(op_b), .bm(branch_metric),
    .survivor(acs_out), .take_second(acs_second)
  );

  // next-state
  logic [DATA_W-1:0] result_d;
  logic [IDX_W-1:0]  dest_d;
  alu_flags_t        flags_d;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_SADD, OP_SSUB: result_d = arith_out;
      OP_AND, OP_OR, OP_XOR:            result_d = logic_out;
      default:                          result_d = acs_out;
    endcase
    dest_d           = dest_sel ? src_b_idx : src_a_idx;
    flags_d.zero     = (result_d == '0);
    flags_d.neg      = result_d[DATA_W-1];
    flags_d.decision = (op == OP_ACS) && acs_second;
  end

  // registers with explicit load enable
  logic              valid_q;
  logic [DATA_W-1:0] result_q;
  logic [IDX_W-1:0]  dest_q;
  alu_flags_t        flags_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      dest_q   <= '0;
      flags_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= result_d;
        dest_q   <= dest_d;
        flags_q  <= flags_d;
      end
    end
  end

  assign out_valid     = valid_q;
  assign result        = result_q;
  assign dest_idx      = dest_q;
  assign flag_zero     = flags_q.zero;
  assign flag_neg      = flags_q.neg;
  assign flag_decision = flags_q.decision;
endmodule

// File: rtl/acs_alu_chk.sv
module acs_alu_chk #(
  parameter int DATA_W = 40,
  parameter int LANE_W = 16,
  parameter int BM_W   = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              in_valid,
  input logic [2:0]        opcode,
  input logic [DATA_W-1:0] op_a,
  input logic [BM_W-1:0]   branch_metric,
  input logic [IDX_W-1:0]  src_a_idx,
  input logic [IDX_W-1:0]  src_b_idx,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [IDX_W-1:0]  dest_idx,
  input logic              flag_zero,
  input logic              flag_neg,
  input logic              flag_decision
);
  localparam int SPLIT_W = 2 * LANE_W;
  localparam int EXT_W   = DATA_W - SPLIT_W;

  logic [DATA_W-1:0] first_sum;
  logic              split_op;
  assign first_sum = op_a + {{(DATA_W-BM_W){branch_metric[BM_W-1]}}, branch_metric};
  assign split_op  = (opcode == 3'd5) || (opcode == 3'd6);

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(result) && $stable(dest_idx) && $stable(flag_decision)));

  assert_split_sext_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && split_op) |=> (result[DATA_W-1:SPLIT_W] == {EXT_W{result[SPLIT_W-1]}}));

  assert_acs_not_above_first_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && opcode == 3'd7) |=> ($signed(result) <= $signed($past(first_sum))));

  assert_dest_is_source_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> (dest_idx == $past(src_a_idx) || dest_idx == $past(src_b_idx)));

  assert_decision_only_acs_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && opcode != 3'd7) |=> !flag_decision);

  assert_flags_track_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (flag_neg == result[DATA_W-1] && flag_zero == (result == '0)));
endmodule

bind acs_alu acs_alu_chk #(
  .DATA_W(DATA_W), .LANE_W(LANE_W), .BM_W(BM_W), .IDX_W(IDX_W)
) u_acs_alu_chk (
  .clk(clk), .rst_int_n(rst_int_n), .in_valid(in_valid), .opcode(opcode),
  .op_a(op_a), .branch_metric(branch_metric), .src_a_idx(src_a_idx),
  .src_b_idx(src_b_idx), .out_valid(out_valid), .result(result),
  .dest_idx(dest_idx), .flag_zero(flag_zero), .flag_neg(flag_neg),
  .flag_decision(flag_decision)
);

// File: tb/test_acs_alu.sv
module test_acs_alu;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  opcode;
  logic [39:0] op_a, op_b;
  logic [15:0] branch_metric;
  logic [2:0]  src_a_idx, src_b_idx;
  logic        dest_sel;
  logic        out_valid;
  logic [39:0] result;
  logic [2:0]  dest_idx;
  logic        flag_zero, flag_neg, flag_decision;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  acs_alu i_acs_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .branch_metric(branch_metric),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dest_sel(dest_sel),
    .out_valid(out_valid), .result(result), .dest_idx(dest_idx),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_decision(flag_decision)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one operation on a falling edge; return on the next falling edge,
  // where the registered result is visible
  task automatic issue(input logic [2:0] op, input logic [39:0] a, input logic [39:0] b,
                       input logic [15:0] bm, input logic [2:0] ia, input logic [2:0] ib,
                       input logic sel);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; branch_metric = bm;
    src_a_idx = ia; src_b_idx = ib; dest_sel = sel; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [39:0] r, input logic [2:0] d,
                            input logic z, input logic n, input logic dec);
    check({req, " out_valid"}, {39'd0, out_valid}, 40'd1);
    check({req, " result"},    result, r);
    check({req, " dest_idx"},  {37'd0, dest_idx}, {37'd0, d});
    check({req, " zero"},      {39'd0, flag_zero}, {39'd0, z});
    check({req, " neg"},       {39'd0, flag_neg}, {39'd0, n});
    check({req, " decision"},  {39'd0, flag_decision}, {39'd0, dec});
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; op_a = '0; op_b = '0;
    branch_metric = '0; src_a_idx = '0; src_b_idx = '0; dest_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid", {39'd0, out_valid}, 40'd0);
    check("R1 result", result, 40'd0);
    check("R1 dest_idx", {37'd0, dest_idx}, 40'd0);
    check("R1 flags", {37'd0, flag_zero, flag_neg, flag_decision}, 40'd0);
  endtask

  task automatic test_add_sub();
    issue(3'd0, 40'd5, 40'd7, 16'd0, 3'd1, 3'd2, 1'b0);
    expect_out("R3 add", 40'd12, 3'd1, 1'b0, 1'b0, 1'b0);
    issue(3'd0, 40'hFF_FFFF_FFFF, 40'd1, 16'd0, 3'd3, 3'd4, 1'b1);
    expect_out("R3 add wrap", 40'd0, 3'd4, 1'b1, 1'b0, 1'b0);
    issue(3'd1, 40'd3, 40'd5, 16'd0, 3'd0, 3'd7, 1'b0);
    expect_out("R3 sub", 40'hFF_FFFF_FFFE, 3'd0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic test_logic();
    issue(3'd2, 40'hF0_F0F0_1234, 40'hFF_00FF_0F0F, 16'd0, 3'd2, 3'd5, 1'b0);
    expect_out("R4 and", 40'hF0_00F0_0204, 3'd2, 1'b0, 1'b1, 1'b0);
    issue(3'd3, 40'h00_1200_0034, 40'h00_0056_7800, 16'd0, 3'd2, 3'd5, 1'b1);
    expect_out("R4 or", 40'h00_1256_7834, 3'd5, 1'b0, 1'b0, 1'b0);
    issue(3'd4, 40'h5A_5A5A_5A5A, 40'h5A_5A5A_5A5A, 16'd0, 3'd6, 3'd1, 1'b0);
    expect_out("R4 xor", 40'd0, 3'd6, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic test_split();
    // low lane carry out must not reach high lane; upper operand bits ignored
    issue(3'd5, 40'hAB_7FFF_FFFF, 40'h12_0001_0001, 16'd0, 3'd1, 3'd2, 1'b0);
    expect_out("R5 split add", 40'hFF_8000_0000, 3'd1, 1'b0, 1'b1, 1'b0);
    // low lane borrow must not reach high lane
    issue(3'd6, 40'h77_0001_0000, 40'h33_0000_0001, 16'd0, 3'd3, 3'd2, 1'b1);
    expect_out("R5 split sub", 40'h00_0001_FFFF, 3'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_acs();
    issue(3'd7, 40'd100, 40'd200, 16'd10, 3'd0, 3'd1, 1'b0);
    expect_out("R6 first wins", 40'd110, 3'd0, 1'b0, 1'b0, 1'b0);
    issue(3'd7, 40'd300, 40'd100, 16'hFFFB, 3'd4, 3'd5, 1'b1);
    expect_out("R6 second wins", 40'd105, 3'd5, 1'b0, 1'b0, 1'b1);
    issue(3'd7, 40'hFF_FFFF_FFEC, 40'd10, 16'd0, 3'd6, 3'd7, 1'b0);
    expect_out("R6 negative metric", 40'hFF_FFFF_FFEC, 3'd6, 1'b0, 1'b1, 1'b0);
    issue(3'd7, 40'd50, 40'd70, 16'd10, 3'd2, 3'd3, 1'b1);
    expect_out("R7 tie", 40'd60, 3'd3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_dest_and_hold();
    issue(3'd0, 40'd1, 40'd2, 16'd0, 3'd6, 3'd2, 1'b1);
    expect_out("R8 dest b", 40'd3, 3'd2, 1'b0, 1'b0, 1'b0);
    issue(3'd0, 40'd1, 40'd2, 16'd0, 3'd6, 3'd2, 1'b0);
    expect_out("R8 dest a", 40'd3, 3'd6, 1'b0, 1'b0, 1'b0);
    // decision clears on a non-ACS op after an ACS win
    issue(3'd7, 40'd9, 40'd1, 16'd0, 3'd0, 3'd1, 1'b0);
    expect_out("R9 acs set", 40'd1, 3'd0, 1'b0, 1'b0, 1'b1);
    issue(3'd1, 40'd4, 40'd4, 16'd0, 3'd0, 3'd1, 1'b0);
    expect_out("R9 decision clear", 40'd0, 3'd0, 1'b1, 1'b0, 1'b0);
    // idle cycles with changing inputs leave outputs unchanged
    opcode = 3'd0; op_a = 40'd77; op_b = 40'd88; dest_sel = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle valid", {39'd0, out_valid}, 40'd0);
    check("R2 idle result", result, 40'd0);
    check("R2 idle dest", {37'd0, dest_idx}, 40'd0);
    check("R2 idle zero", {39'd0, flag_zero}, 40'd1);
  endtask

  initial begin
    test_reset();
    test_add_sub();
    test_logic();
    test_split();
    test_acs();
    test_dest_and_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule